// File: doc/BRIEF.md
# Endpoint DMA Enable Bank

This block holds one DMA enable bit for each endpoint of a USB device controller. Software changes the bits through a small single-cycle register bus with three registers. A status register reads back the whole vector. A set register turns on the endpoints whose data bits are 1. A clear register turns off the endpoints whose data bits are 1. The set and clear registers are write-only. Writing 0 to any bit of either one leaves that endpoint as it was.

The DMA engine feeds two vectors into the block. The first flags, for each endpoint, that a transfer is running. The second pulses for one cycle when a transfer on an endpoint fails. A disable request that arrives while a transfer is running is held as pending. The bit falls only when that transfer ends. An error clears the bit at once.

The block also holds a proceed flag. The DMA engine sets it with a one-cycle pulse. Any write to the clear register resets it. The two lowest endpoints are control endpoints and never get DMA.

Top module: `ep_dma_enable_regs`

## Requirements
- R1: After reset, every enable bit is 0, the proceed flag is 0 and the read data is 0.
- R2: A write to the set register (address 1) with data bit i at 1 makes enable bit i read 1 after the next clock edge. Data bits at 0 change nothing.
- R3: A write to the clear register (address 2) with data bit i at 1 drives enable bit i to 0 after the next edge, provided endpoint i has no transfer running. Data bits at 0 change nothing.
- R4: Enable bits 0 and 1 (the control OUT and control IN endpoints) are always 0, even after a set-register write with those bits at 1.
- R5: Any write to the clear register drives the proceed flag to 0 after the next edge, whatever the write data, all zeros included. A proceed pulse raises the flag. When a proceed pulse and a clear write arrive in the same cycle, the flag ends at 0.
- R6: A clear request for an endpoint that is enabled and has a transfer running leaves its enable bit at 1. The bit stays at 1 for as long as the transfer-running input stays high. The bit goes to 0 after the first edge at which that input is low.
- R7: A set-register write to a bit with a pending clear cancels the clear, so the bit stays 1 after the transfer ends.
- R8: An error pulse for endpoint i drives enable bit i to 0 after the next edge. This also holds when a set write for that bit arrives in the same cycle.
- R9: Read data is registered. One edge after an address is presented, the read data holds the enable vector when the address is the status register (address 0), and 0 for any other address. Writes to address 0 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data, one bit per endpoint |
| bus_rdata | output | 32 | Registered read data |
| xfer_busy | input | 32 | Transfer running, per endpoint |
| dma_err | input | 32 | One-cycle error pulse, per endpoint |
| proceed_set | input | 1 | One-cycle pulse that raises the proceed flag |
| dma_en | output | 32 | Enable vector, per endpoint |
| proceed | output | 1 | Proceed flag |

## Verification
The hardest case to reach is the deferred disable. It needs an endpoint that is enabled, a running transfer on that endpoint, a clear write that lands during the transfer, and then either the end of the transfer or a new set write before that end. The directed part of the bench raises the transfer input for one endpoint first and only then writes the clear register. It holds the transfer for several cycles and checks that the bit stays up. It then lowers the input and checks that the bit drops on that edge. A second endpoint runs the same sequence with a set write placed before the transfer ends.

// File: rtl/epdma_pkg.sv
package epdma_pkg;
   // Register selected by the current bus address
   typedef enum logic [1:0] {
      SEL_STATUS = 2'd0,
      SEL_SET    = 2'd1,
      SEL_CLR    = 2'd2,
      SEL_NONE   = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/epdma_decode.sv
module epdma_decode
   import epdma_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 32,
   parameter int STATUS_ADDR = 0,
   parameter int SET_ADDR    = 1,
   parameter int CLR_ADDR    = 2
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output reg_sel_e          sel,
   output logic [DATA_W-1:0] set_mask,
   output logic [DATA_W-1:0] clr_mask,
   output logic              clr_hit
);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STATUS_ADDR);
   localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(SET_ADDR);
   localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(CLR_ADDR);

   initial begin
      assert (STATUS_ADDR != SET_ADDR && STATUS_ADDR != CLR_ADDR && SET_ADDR != CLR_ADDR)
         else $error("register addresses must differ");
      assert (CLR_ADDR < (1 << ADDR_W) && SET_ADDR < (1 << ADDR_W) && STATUS_ADDR < (1 << ADDR_W))
         else $error("register address does not fit ADDR_W");
   end

   always_comb begin
      if (addr == A_STAT)      sel = SEL_STATUS;
      else if (addr == A_SET)  sel = SEL_SET;
      else if (addr == A_CLR)  sel = SEL_CLR;
      else                     sel = SEL_NONE;
   end

   assign clr_hit  = wr && (sel == SEL_CLR);
   assign set_mask = (wr && sel == SEL_SET) ? wdata : '0;
   assign clr_mask = clr_hit ? wdata : '0;
endmodule

// File: rtl/epdma_ep_cells.sv
module epdma_ep_cells #(
   parameter int NUM_EP   = 32,
   parameter int NUM_CTRL = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_EP-1:0] set_mask,
   input  logic [NUM_EP-1:0] clr_mask,
   input  logic [NUM_EP-1:0] busy,
   input  logic [NUM_EP-1:0] err,
   output logic [NUM_EP-1:0] en
);
   initial begin
      assert (NUM_CTRL >= 0 && NUM_CTRL < NUM_EP)
         else $error("NUM_CTRL must be below NUM_EP");
   end

   for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
      if (i < NUM_CTRL) begin : g_ctrl
         // Control endpoint: no storage, always disabled
         logic unused_ok;
         assign unused_ok = &{1'b0, set_mask[i], clr_mask[i], busy[i], err[i]};
         assign en[i] = 1'b0;
      end else begin : g_data
         logic en_q, pend_q, en_d, pend_d;

         always_comb begin
            en_d   = en_q;
            pend_d = pend_q;
            // deferred disable completes once the transfer is over
            if (pend_q && !busy[i]) begin
               en_d   = 1'b0;
               pend_d = 1'b0;
            end
            if (set_mask[i]) begin
               en_d   = 1'b1;
               pend_d = 1'b0;
            end
            if (clr_mask[i]) begin
               if (busy[i] && en_d) pend_d = 1'b1;
               else begin
                  en_d   = 1'b0;
                  pend_d = 1'b0;
               end
            end
            if (err[i]) begin
               en_d   = 1'b0;
               pend_d = 1'b0;
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               en_q   <= 1'b0;
               pend_q <= 1'b0;
            end else begin
               en_q   <= en_d;
               pend_q <= pend_d;
            end
         end

         assign en[i] = en_q;

         a_r2_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
            (set_mask[i] && !err[i]) |=> en_q);
         a_r3_clr_idle: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_mask[i] && !busy[i]) |=> !en_q);
         a_r6_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
            (en_q && clr_mask[i] && busy[i] && !err[i]) |=> en_q);
         a_r8_err_clears: assert property (@(posedge clk) disable iff (!rst_n)
            err[i] |=> !en_q);
      end
   end
endmodule

// File: rtl/epdma_rdport.sv
module epdma_rdport
   import epdma_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  reg_sel_e          sel,
   input  logic [DATA_W-1:0] en,
   output logic [DATA_W-1:0] rdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 rdata <= '0;
      else if (sel == SEL_STATUS) rdata <= en;
      else                        rdata <= '0;
   end
endmodule

// File: rtl/ep_dma_enable_regs.sv
module ep_dma_enable_regs
   import epdma_pkg::*;
#(
   parameter int NUM_EP      = 32,
   parameter int NUM_CTRL    = 2,
   parameter int ADDR_W      = 4,
   parameter int STATUS_ADDR = 0,
   parameter int SET_ADDR    = 1,
   parameter int CLR_ADDR    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [NUM_EP-1:0] bus_wdata,
   output logic [NUM_EP-1:0] bus_rdata,
   input  logic [NUM_EP-1:0] xfer_busy,
   input  logic [NUM_EP-1:0] dma_err,
   input  logic              proceed_set,
   output logic [NUM_EP-1:0] dma_en,
   output logic              proceed
);
   localparam int DATA_W = NUM_EP;

   reg_sel_e          sel;
   logic [DATA_W-1:0] set_mask, clr_mask;
   logic              clr_hit;

   epdma_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .STATUS_ADDR(STATUS_ADDR), .SET_ADDR(SET_ADDR), .CLR_ADDR(CLR_ADDR)
   ) u_dec (
      .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
      .sel(sel), .set_mask(set_mask), .clr_mask(clr_mask), .clr_hit(clr_hit)
   );

   epdma_ep_cells #(.NUM_EP(NUM_EP), .NUM_CTRL(NUM_CTRL)) u_cells (
      .clk(clk), .rst_n(rst_n),
      .set_mask(set_mask), .clr_mask(clr_mask),
      .busy(xfer_busy), .err(dma_err), .en(dma_en)
   );

   epdma_rdport #(.DATA_W(DATA_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .sel(sel), .en(dma_en), .rdata(bus_rdata)
   );

   // proceed flag: a clear-register write beats a set pulse
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           proceed <= 1'b0;
      else if (clr_hit)     proceed <= 1'b0;
      else if (proceed_set) proceed <= 1'b1;
   end

   a_r5_proceed_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(CLR_ADDR)) |=> !proceed);
endmodule

// File: tb/ep_dma_enable_regs_test.sv
module ep_dma_enable_regs_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] xfer_busy = '0;
   logic [31:0] dma_err = '0;
   logic        proceed_set = 1'b0;
   logic [31:0] dma_en;
   logic        proceed;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   ep_dma_enable_regs uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .xfer_busy(xfer_busy),
      .dma_err(dma_err), .proceed_set(proceed_set), .dma_en(dma_en),
      .proceed(proceed)
   );

   localparam logic [3:0] A_ST = 4'd0, A_SET = 4'd1, A_CLR = 4'd2;

   typedef struct packed {
      logic [3:0]  addr;
      logic        wr;
      logic [31:0] wdata;
      logic        pset;
      logic [31:0] exp_en;
      logic        exp_pr;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VT [NV] = '{
      '{A_SET, 1'b1, 32'hF000_000F, 1'b0, 32'hF000_000C, 1'b0}, // R2 R4
      '{A_SET, 1'b1, 32'h0000_0000, 1'b0, 32'hF000_000C, 1'b0}, // R2 zero write
      '{A_ST,  1'b0, 32'h0000_0000, 1'b1, 32'hF000_000C, 1'b1}, // R5 pulse
      '{A_CLR, 1'b1, 32'h0000_0000, 1'b0, 32'hF000_000C, 1'b0}, // R5 zero clear, R3
      '{A_ST,  1'b0, 32'h0000_0000, 1'b1, 32'hF000_000C, 1'b1}, // R5
      '{A_CLR, 1'b1, 32'h0000_0008, 1'b0, 32'hF000_0004, 1'b0}, // R3
      '{A_SET, 1'b1, 32'h00FF_0000, 1'b0, 32'hF0FF_0004, 1'b0}, // R2
      '{A_ST,  1'b1, 32'hFFFF_FFFF, 1'b0, 32'hF0FF_0004, 1'b0}, // R9 status write ignored
      '{A_CLR, 1'b1, 32'h0000_0000, 1'b1, 32'hF0FF_0004, 1'b0}, // R5 clear beats pulse
      '{A_CLR, 1'b1, 32'hFFFF_FFFF, 1'b0, 32'h0000_0000, 1'b0}  // R3
   };

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(logic [3:0] a, logic w, logic [31:0] d, logic ps);
      @(negedge clk);
      bus_addr = a; bus_wr = w; bus_wdata = d; proceed_set = ps;
      @(posedge clk);
      #1;
      bus_wr = 1'b0; proceed_set = 1'b0; dma_err = '0;
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1 en", dma_en, 32'h0);
      chk("R1 proceed", {31'b0, proceed}, 32'h0);
      chk("R1 rdata", bus_rdata, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int k = 0; k < NV; k++) begin
         step(VT[k].addr, VT[k].wr, VT[k].wdata, VT[k].pset);
         chk($sformatf("R2/R3/R5 vec%0d en", k), dma_en, VT[k].exp_en);
         chk($sformatf("R5 vec%0d proceed", k), {31'b0, proceed}, {31'b0, VT[k].exp_pr});
      end

      // R4: control endpoints cannot be set
      step(A_SET, 1'b1, 32'h0000_0003, 1'b0);
      chk("R4 ctrl bits", dma_en, 32'h0);
      step(A_ST, 1'b0, 32'h0, 1'b0);
      chk("R4 rdata ctrl", bus_rdata, 32'h0);

      // R6: deferred disable on endpoint 5
      step(A_SET, 1'b1, 32'h0000_0020, 1'b0);
      xfer_busy[5] = 1'b1;
      step(A_CLR, 1'b1, 32'h0000_0020, 1'b0);
      chk("R6 held at request", dma_en, 32'h0000_0020);
      step(A_ST, 1'b0, 32'h0, 1'b0);
      step(A_ST, 1'b0, 32'h0, 1'b0);
      chk("R6 held while busy", dma_en, 32'h0000_0020);
      @(negedge clk) xfer_busy[5] = 1'b0;
      @(posedge clk); #1;
      chk("R6 drops at end", dma_en, 32'h0);

      // R7: set cancels pending clear on endpoint 6
      step(A_SET, 1'b1, 32'h0000_0040, 1'b0);
      xfer_busy[6] = 1'b1;
      step(A_CLR, 1'b1, 32'h0000_0040, 1'b0);
      step(A_SET, 1'b1, 32'h0000_0040, 1'b0);
      @(negedge clk) xfer_busy[6] = 1'b0;
      @(posedge clk); #1;
      step(A_ST, 1'b0, 32'h0, 1'b0);
      chk("R7 pending cancelled", dma_en, 32'h0000_0040);

      // R8: error clears; error beats simultaneous set
      step(A_SET, 1'b1, 32'h0000_0080, 1'b0);
      @(negedge clk); dma_err[7] = 1'b1;
      step(A_ST, 1'b0, 32'h0, 1'b0);
      chk("R8 error clears", dma_en, 32'h0000_0040);
      @(negedge clk); dma_err[8] = 1'b1;
      step(A_SET, 1'b1, 32'h0000_0100, 1'b0);
      chk("R8 error beats set", dma_en, 32'h0000_0040);

      // R9: read data per address, one edge latency
      step(A_ST, 1'b0, 32'h0, 1'b0);
      chk("R9 status read", bus_rdata, 32'h0000_0040);
      step(A_SET, 1'b0, 32'h0, 1'b0);
      chk("R9 set reg reads 0", bus_rdata, 32'h0);
      step(A_CLR, 1'b0, 32'h0, 1'b0);
      chk("R9 clr reg reads 0", bus_rdata, 32'h0);
      chk("R9 no side effect", dma_en, 32'h0000_0040);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule